// File: doc/BRIEF.md
# Scaled system timestamp counter

This block keeps a free-running 64-bit time stamp for a whole chip. It is clocked by the system clock but counts only on single-cycle pulses of a slow reference tick. On each tick the count grows by a programmable step rather than by one, so a low-rate reference can stand in for the higher rate that software is told about. Every reader taps the same registered count, so all agents see the same value in the same cycle.

Software controls the counter only through a small word-addressed register window. Through it, software enables counting, loads a new count as two 32-bit halves that take effect together, sets the step and sets the rate in Hz that is reported to software. A debug-halt input freezes the count while a debugger holds the system, but only if software has allowed this.

Top module: `scaled_tstamp`

## Requirements
- R1: After reset, the count is 0, the control word reads 0, the step reads 1 and the rate register reads its reset parameter value (24000000 by default).
- R2: Control bit 0 (address 0x00) enables counting. While it is clear, ticks are ignored. While it is set, each tick adds the step, and the count shows the sum in the cycle after the tick.
- R3: The step register (address 0x10, the low 16 bits of the write) sets the amount added per tick. A write whose low 16 bits are zero is ignored, and the old step is kept.
- R4: If control bit 1 is set and dbg_halt is high, ticks are ignored. If control bit 1 is clear, dbg_halt has no effect.
- R5: A write to address 0x08 only stages the low half and leaves the count unchanged. A write to address 0x0C loads {written high half, staged low half} into the count in the next cycle. A load in the same cycle as a tick wins, and the tick is dropped.
- R6: The rate register (address 0x14) accepts only writes from 1 to 50000000. Any other value is ignored.
- R7: A read request returns data one cycle later, with rd_valid high for exactly that cycle. The count reads at 0x08 (low half) and 0x0C (high half). Unmapped addresses read 0. The count is presented zero-extended to 64 bits.
- R8: The count wraps modulo 2^64 with no indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle reference tick pulse |
| dbg_halt | input | 1 | Debugger halt request |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write byte address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Register read byte address |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| count_out | output | 64 | Current count, zero-extended |

## Verification
A wrong step, a lost enable or a wrongly latched halt shows up on count_out one cycle after the first affected tick, as a value off by a whole step. A broken staging register or a wrong load priority shows up the cycle after the high-half write, as a wrong low half or as a value off by one extra step. A corrupt control, step or rate register shows up at rd_data one cycle after the read. A false or missing rd_valid shows up in that same cycle.

// File: rtl/tstamp_pkg.sv
package tstamp_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] A_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] A_CLO  = 8'h08;
  localparam logic [ADDR_W-1:0] A_CHI  = 8'h0C;
  localparam logic [ADDR_W-1:0] A_MULT = 8'h10;
  localparam logic [ADDR_W-1:0] A_FREQ = 8'h14;

  typedef struct packed {
    logic hod;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/tstamp_regs.sv
module tstamp_regs
  import tstamp_pkg::*;
#(
  parameter int MULT_W   = 16,
  parameter int FREQ_W   = 32,
  parameter int FREQ_MIN = 1,
  parameter int FREQ_MAX = 50_000_000,
  parameter int FREQ_RST = 24_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output ctrl_t             ctrl,
  output logic [MULT_W-1:0] mult,
  output logic [FREQ_W-1:0] freq,
  output logic              load_go,
  output logic [63:0]       load_word
);
  localparam logic [DATA_W-1:0] FMIN = DATA_W'(FREQ_MIN);
  localparam logic [DATA_W-1:0] FMAX = DATA_W'(FREQ_MAX);

  logic [DATA_W-1:0] lo_stage;
  logic              freq_ok;
  logic              mult_ok;

  assign freq_ok   = (wr_data >= FMIN) && (wr_data <= FMAX);
  assign mult_ok   = (wr_data[MULT_W-1:0] != '0);
  assign load_go   = wr_en && (wr_addr == A_CHI);
  assign load_word = {wr_data, lo_stage};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= '0;
      mult     <= MULT_W'(1);
      freq     <= FREQ_W'(FREQ_RST);
      lo_stage <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: ctrl <= ctrl_t'(wr_data[1:0]);
        A_CLO:  lo_stage <= wr_data;
        A_MULT: if (mult_ok) mult <= wr_data[MULT_W-1:0];
        A_FREQ: if (freq_ok) freq <= wr_data[FREQ_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst) begin
      AST_MULT_NONZERO: assert (mult != '0); // R3
      AST_FREQ_RANGE: assert (32'(freq) >= FMIN && 32'(freq) <= FMAX); // R6
    end
  end
endmodule

// File: rtl/tstamp_count.sv
module tstamp_count #(
  parameter int COUNT_W = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [COUNT_W-1:0] load_val,
  input  logic               adv,
  input  logic [COUNT_W-1:0] inc,
  output logic [COUNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (adv)  cnt <= cnt + inc;
  end

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    load |=> cnt == $past(load_val)); // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv) |=> $stable(cnt)); // R2
  AST_STEP_ADDS: assert property (@(posedge clk) disable iff (rst)
    (!load && adv) |=> cnt == $past(cnt) + $past(inc)); // R8
endmodule

// File: rtl/tstamp_readmux.sv
module tstamp_readmux
  import tstamp_pkg::*;
#(
  parameter int MULT_W = 16,
  parameter int FREQ_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  ctrl_t             ctrl,
  input  logic [MULT_W-1:0] mult,
  input  logic [FREQ_W-1:0] freq,
  input  logic [63:0]       cnt64,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    case (rd_addr)
      A_CTRL:  sel = DATA_W'(ctrl);
      A_CLO:   sel = cnt64[31:0];
      A_CHI:   sel = cnt64[63:32];
      A_MULT:  sel = DATA_W'(mult);
      A_FREQ:  sel = DATA_W'(freq);
      default: sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= sel;
    end
  end

  AST_RD_PULSE: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid); // R7
  AST_RD_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid); // R7
endmodule

// File: rtl/scaled_tstamp.sv
module scaled_tstamp
  import tstamp_pkg::*;
#(
  parameter int COUNT_W  = 64,
  parameter int MULT_W   = 16,
  parameter int FREQ_W   = 32,
  parameter int FREQ_MIN = 1,
  parameter int FREQ_MAX = 50_000_000,
  parameter int FREQ_RST = 24_000_000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ref_tick,
  input  logic        dbg_halt,
  input  logic        wr_en,
  input  logic [7:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic        rd_en,
  input  logic [7:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        rd_valid,
  output logic [63:0] count_out
);
  ctrl_t              ctrl;
  logic [MULT_W-1:0]  mult;
  logic [FREQ_W-1:0]  freq;
  logic               load_go;
  logic [63:0]        load_word;
  logic               adv;
  logic [COUNT_W-1:0] cnt;

  tstamp_regs #(
    .MULT_W(MULT_W), .FREQ_W(FREQ_W), .FREQ_MIN(FREQ_MIN),
    .FREQ_MAX(FREQ_MAX), .FREQ_RST(FREQ_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl(ctrl), .mult(mult), .freq(freq),
    .load_go(load_go), .load_word(load_word)
  );

  assign adv = ctrl.en && ref_tick && !(ctrl.hod && dbg_halt);

  tstamp_count #(.COUNT_W(COUNT_W)) u_count (
    .clk(clk), .rst(rst), .load(load_go),
    .load_val(load_word[COUNT_W-1:0]), .adv(adv),
    .inc(COUNT_W'(mult)), .cnt(cnt)
  );

  generate
    if (COUNT_W < 64) begin : g_pad
      assign count_out = {{(64-COUNT_W){1'b0}}, cnt};
    end else begin : g_full
      assign count_out = cnt;
    end
  endgenerate

  tstamp_readmux #(.MULT_W(MULT_W), .FREQ_W(FREQ_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .ctrl(ctrl), .mult(mult), .freq(freq), .cnt64(count_out),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (ctrl.en && ctrl.hod && dbg_halt && !load_go) |=> $stable(count_out)); // R4
  AST_OFF_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.en && !load_go) |=> $stable(count_out)); // R2
endmodule

// File: tb/sim_scaled_tstamp.sv
module sim_scaled_tstamp;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_tick = 1'b0, dbg_halt = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic [63:0] count_out;

  int checks = 0, failures = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  scaled_tstamp u0 (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .dbg_halt(dbg_halt),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_valid(rd_valid), .count_out(count_out)
  );

  task automatic check64(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic tick();
    @(negedge clk); ref_tick = 1;
    @(negedge clk); ref_tick = 0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string req);
    @(negedge clk); rd_en = 1; rd_addr = a;
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk); rd_en = 0;
  endtask

  // monitor: compares each returned read with the queued expectation
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R7 actual=unexpected rd_valid data=%h expected=no read", rd_data);
      end else begin
        logic [31:0] e; string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        if (rd_data !== e) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", t, rd_data, e);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check64("R1", count_out, 64'd0);
    rd(8'h00, 32'd0, "R1");
    rd(8'h10, 32'd1, "R1");
    rd(8'h14, 32'd24_000_000, "R1");
    tick();
    check64("R2", count_out, 64'd0);
    wr(8'h00, 32'd1);
    repeat (3) tick();
    check64("R2", count_out, 64'd3);
    wr(8'h10, 32'd10);
    tick();
    check64("R3", count_out, 64'd13);
    wr(8'h10, 32'h0001_0000);
    rd(8'h10, 32'd10, "R3");
    tick();
    check64("R3", count_out, 64'd23);
    wr(8'h00, 32'd3); dbg_halt = 1;
    tick();
    check64("R4", count_out, 64'd23);
    wr(8'h00, 32'd1);
    tick();
    check64("R4", count_out, 64'd33);
    dbg_halt = 0;
    wr(8'h08, 32'h0000_0005);
    check64("R5", count_out, 64'd33);
    wr(8'h0C, 32'h0000_0001);
    check64("R5", count_out, 64'h1_0000_0005);
    rd(8'h08, 32'h5, "R7");
    rd(8'h0C, 32'h1, "R7");
    wr(8'h08, 32'h0000_0100);
    @(negedge clk); wr_en = 1; wr_addr = 8'h0C; wr_data = 32'h2; ref_tick = 1;
    @(negedge clk); wr_en = 0; ref_tick = 0;
    check64("R5", count_out, 64'h2_0000_0100);
    wr(8'h08, 32'hFFFF_FFFE);
    wr(8'h0C, 32'hFFFF_FFFF);
    tick();
    check64("R8", count_out, 64'd8);
    wr(8'h14, 32'd50_000_000);
    rd(8'h14, 32'd50_000_000, "R6");
    wr(8'h14, 32'd50_000_001);
    rd(8'h14, 32'd50_000_000, "R6");
    wr(8'h14, 32'd0);
    rd(8'h14, 32'd50_000_000, "R6");
    wr(8'h14, 32'd1);
    rd(8'h14, 32'd1, "R6");
    rd(8'h20, 32'd0, "R7");
    rd(8'h00, 32'd1, "R2");
    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R7 actual=%0d pending expected=0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2_000_000;
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule